// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

The block takes 32-bit audio words from a transmit FIFO and shifts them out, most significant bit first, on one serial data line. An external master supplies the bit clock and the frame clock. Both are sampled in the system clock domain. Every falling edge of the bit clock is one bit time, and the data line changes only at those bit times.

Two framings are supported. In stereo-pair framing, each transition of the frame clock starts a new half frame. Within that half, the word can be placed one bit late (standard), flush with the edge (left-justified), or flush with the end of its slot (right-justified). In PCM framing, a rising frame clock marks the frame start, and data begins zero to three bit times later. In both framings a slot is one word width long (32 bit times).

A width field limits how many low-order bits of each word are sent. A channel-count field sets how many slots follow each sync. If the FIFO has nothing to give when a slot starts, the slot carries zeros and an underrun pulse is raised.

Top module: `aud_serial_tx`

## Requirements
- R1: While reset is asserted, and directly after it, `sdo`, `fifo_pop` and `underrun` are all low.
- R2: With `cfg_pcm`=0 and `cfg_just`=0 (standard), each frame clock transition starts a half frame. The first slot's MSB appears one bit time after the transition bit, and each word is sent MSB first. Code 3 behaves the same as code 0.
- R3: With `cfg_pcm`=0 and `cfg_just`=1 (left-justified), the MSB appears on the same bit time as the frame clock transition.
- R4: With `cfg_pcm`=0 and `cfg_just`=2 (right-justified), the word's bit 0 is on the last bit time of its 32-bit slot. Bit times before the valid bits carry zero.
- R5: With `cfg_pcm`=1, only a rising frame clock is a sync, and `cfg_just` is ignored. The first data bit comes `cfg_delay` (0..3) bit times after the sync bit, and slots follow back to back.
- R6: `cfg_width_m1` holds the sample width minus one. Only bits [width-1:0] of a FIFO word are sent. In non-right-justified layouts, the slot positions past the width carry zero.
- R7: `cfg_chans` codes 0..3 mean 2, 4, 6 or 8 channels. Stereo-pair framing sends channels/2 slots per half frame, and PCM framing sends all channels after each sync. After that the line is zero and no word is taken.
- R8: At each slot start with the FIFO not empty, `fifo_pop` is high for exactly one clock, in the cycle the word is captured.
- R9: At a slot start with the FIFO empty, no word is taken, the slot is all zeros, and `underrun` pulses high for one clock.
- R10: `sdo` changes only in response to a falling edge of the bit clock. Each bit is held stable through the following high phase.
- R11: Before the first frame sync after reset, `sdo` stays low and no word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Bit clock from the external master |
| fsync_in | input | 1 | Frame clock / frame sync from the external master |
| cfg_pcm | input | 1 | 0 = stereo-pair framing, 1 = PCM framing |
| cfg_just | input | 2 | Justification in stereo-pair framing: 0 standard, 1 left, 2 right, 3 as 0 |
| cfg_delay | input | 2 | PCM sync-to-data delay in bit times |
| cfg_width_m1 | input | 5 | Valid sample width minus one |
| cfg_chans | input | 2 | Channel count code: 2, 4, 6, 8 channels |
| fifo_empty | input | 1 | FIFO has no word to give |
| fifo_data | input | 32 | Word at the FIFO head (show-ahead) |
| fifo_pop | output | 1 | Consume the FIFO head this cycle |
| sdo | output | 1 | Serial data out |
| underrun | output | 1 | One-cycle pulse: a slot started with the FIFO empty |

## Verification
The frame sync and a slot load can fall on the same bit time, and a new sync can also arrive on the bit time that still carries the previous slot's last bit. Both collisions are provoked by sweeps that use a PCM delay of 0, and stereo-pair half frames exactly as long as their slots with full 32-bit words. In the latter case the standard layout's LSB spills onto the transition bit. Each bit is judged against a stream built arithmetically from the word sequence, the layout offset and the slot count. FIFO pop and underrun totals are compared per case, including cases that run the FIFO dry partway through a frame.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;

  typedef enum logic [1:0] {
    JUST_STD   = 2'd0,
    JUST_LEFT  = 2'd1,
    JUST_RIGHT = 2'd2,
    JUST_RSVD  = 2'd3
  } just_e;

  typedef struct packed {
    logic       pcm;
    just_e      just;
    logic [1:0] delay;
    logic [1:0] chans;
  } fmt_t;

  // bit times between the sync bit and the first slot start
  function automatic logic [1:0] lead_bits(input fmt_t f);
    logic [1:0] r;
    if (f.pcm) begin
      r = f.delay;
    end else begin
      case (f.just)
        JUST_LEFT, JUST_RIGHT: r = 2'd0;
        default:               r = 2'd1;
      endcase
    end
    return r;
  endfunction

  // slots sent after each sync
  function automatic logic [3:0] slot_count(input fmt_t f);
    logic [3:0] pairs;
    pairs = {2'b00, f.chans} + 4'd1;
    return f.pcm ? (pairs << 1) : pairs;
  endfunction

  function automatic logic right_just(input fmt_t f);
    return (!f.pcm) && (f.just == JUST_RIGHT);
  endfunction

endpackage

// File: rtl/aud_tx_edge.sv
`timescale 1ns/1ps
module aud_tx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic pcm,
  output logic tick,
  output logic sync
);

  logic [SYNC_STAGES-1:0] bclk_s, bclk_s_nxt;
  logic [SYNC_STAGES-1:0] fs_s, fs_s_nxt;
  logic bclk_last, bclk_last_nxt;
  logic fs_ref, fs_ref_nxt;
  logic bclk_cur, fs_cur;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        bclk_s_nxt = bclk_in;
        fs_s_nxt   = fsync_in;
      end
    end else begin : g_chain
      always_comb begin
        bclk_s_nxt = {bclk_s[SYNC_STAGES-2:0], bclk_in};
        fs_s_nxt   = {fs_s[SYNC_STAGES-2:0], fsync_in};
      end
    end
  endgenerate

  assign bclk_cur = bclk_s[SYNC_STAGES-1];
  assign fs_cur   = fs_s[SYNC_STAGES-1];

  always_comb begin
    tick          = bclk_last & ~bclk_cur;
    bclk_last_nxt = bclk_cur;
    fs_ref_nxt    = tick ? fs_cur : fs_ref;
    if (pcm) sync = tick & fs_cur & ~fs_ref;
    else     sync = tick & (fs_cur ^ fs_ref);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_s    <= '1;
      fs_s      <= '0;
      bclk_last <= 1'b1;
      fs_ref    <= 1'b0;
    end else begin
      bclk_s    <= bclk_s_nxt;
      fs_s      <= fs_s_nxt;
      bclk_last <= bclk_last_nxt;
      fs_ref    <= fs_ref_nxt;
    end
  end

  // R10: a bit time lasts at least two system clocks
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/aud_tx_slot.sv
`timescale 1ns/1ps
module aud_tx_slot
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int POS_W  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync,
  input  fmt_t fmt,
  output logic load,
  output logic synced
);

  localparam int SLOT_LOG2 = $clog2(WORD_W);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos, pos_nxt;
  logic [POS_W-1:0] p_now, q, lead, slot_idx, nslots;
  logic synced_nxt;

  always_comb begin
    if (sync)                p_now = '0;
    else if (pos == POS_MAX) p_now = POS_MAX;
    else                     p_now = pos + POS_W'(1);
    lead     = POS_W'(lead_bits(fmt));
    nslots   = POS_W'(slot_count(fmt));
    q        = p_now - lead;
    slot_idx = q >> SLOT_LOG2;
    load     = tick & (synced | sync) & (p_now >= lead)
             & (q[SLOT_LOG2-1:0] == '0) & (slot_idx < nslots);
    pos_nxt    = tick ? p_now : pos;
    synced_nxt = synced | sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= POS_MAX;
      synced <= 1'b0;
    end else begin
      pos    <= pos_nxt;
      synced <= synced_nxt;
    end
  end

endmodule

// File: rtl/aud_tx_shift.sv
`timescale 1ns/1ps
module aud_tx_shift #(
  parameter int WORD_W = 32,
  localparam int WFW   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic              rj,
  input  logic [WFW-1:0]    wm1,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              sdo,
  output logic              underrun
);

  localparam logic [WFW-1:0] TOP_IDX = WFW'(WORD_W - 1);

  logic [WORD_W-1:0] sh, sh_nxt, mask, masked, aligned, cur;
  logic [WFW-1:0]    shamt;
  logic              sdo_nxt, urun_nxt;

  always_comb begin
    for (int i = 0; i < WORD_W; i++) mask[i] = (i <= int'(wm1));
    masked  = fifo_data & mask;
    shamt   = TOP_IDX - wm1;
    aligned = rj ? masked : (masked << shamt);
    if (load) cur = fifo_empty ? '0 : aligned;
    else      cur = sh;
    fifo_pop = load & ~fifo_empty;
    sh_nxt   = tick ? (cur << 1) : sh;
    sdo_nxt  = tick ? cur[WORD_W-1] : sdo;
    urun_nxt = load & fifo_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      sdo      <= 1'b0;
      underrun <= 1'b0;
    end else begin
      sh       <= sh_nxt;
      sdo      <= sdo_nxt;
      underrun <= urun_nxt;
    end
  end

  // R10: output moves only after a bit time
  p_sdo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(sdo));
  // R9: a starved slot begins with a zero bit
  p_underrun_zeros_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !sdo);
  // R9: underrun is a single-cycle pulse
  p_underrun_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

endmodule

// File: rtl/aud_serial_tx.sv
`timescale 1ns/1ps
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int POS_W       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int WFW        = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              fsync_in,
  input  logic              cfg_pcm,
  input  logic [1:0]        cfg_just,
  input  logic [1:0]        cfg_delay,
  input  logic [WFW-1:0]    cfg_width_m1,
  input  logic [1:0]        cfg_chans,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              sdo,
  output logic              underrun
);

  fmt_t fmt;
  logic tick, sync, load, synced, rj;

  always_comb begin
    fmt.pcm   = cfg_pcm;
    fmt.just  = just_e'(cfg_just);
    fmt.delay = cfg_delay;
    fmt.chans = cfg_chans;
    rj        = right_just(fmt);
  end

  aud_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_in  (bclk_in),
    .fsync_in (fsync_in),
    .pcm      (cfg_pcm),
    .tick     (tick),
    .sync     (sync)
  );

  aud_tx_slot #(.WORD_W(WORD_W), .POS_W(POS_W)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .sync   (sync),
    .fmt    (fmt),
    .load   (load),
    .synced (synced)
  );

  aud_tx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (load),
    .rj         (rj),
    .wm1        (cfg_width_m1),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_pop   (fifo_pop),
    .sdo        (sdo),
    .underrun   (underrun)
  );

  // R8: one word per slot start, never on consecutive clocks
  p_pop_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);
  // R11: line quiet until the first sync has been seen
  p_quiet_before_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !sdo);
  // R11: nothing taken before a sync
  p_no_pop_unsynced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !sync) |-> !fifo_pop);

endmodule

// File: tb/aud_serial_tx_test.sv
`timescale 1ns/1ps
module aud_serial_tx_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, bclk, fsync, cfg_pcm;
  logic [1:0]  cfg_just, cfg_delay, cfg_chans;
  logic [4:0]  cfg_width_m1;
  logic        fifo_empty, fifo_pop, sdo, underrun;
  logic [31:0] fifo_data;

  logic [31:0] fmem [0:1023];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int pop_cnt = 0;
  int ur_cnt = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  bit exp_bits [0:4095];
  bit lvl [0:4095];

  assign fifo_data  = fmem[rd_ptr % 1024];
  assign fifo_empty = (rd_ptr == wr_ptr);

  always @(posedge clk) begin
    if (fifo_pop) begin
      rd_ptr  <= rd_ptr + 1;
      pop_cnt <= pop_cnt + 1;
    end
    if (underrun) ur_cnt <= ur_cnt + 1;
  end

  aud_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fsync_in(fsync),
    .cfg_pcm(cfg_pcm), .cfg_just(cfg_just), .cfg_delay(cfg_delay),
    .cfg_width_m1(cfg_width_m1), .cfg_chans(cfg_chans),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .sdo(sdo), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit bitf(input logic [31:0] w, input int wm1,
                              input int b, input bit rj);
    int wd;
    wd = wm1 + 1;
    if (rj) return (b >= 32 - wd) ? w[31-b] : 1'b0;
    return (b < wd) ? w[wd-1-b] : 1'b0;
  endfunction

  task automatic run_case(input bit pcm, input int just, input int dly,
                          input int wm1, input int ch, input int frames,
                          input int extra, input int nwords);
    int n, d, total, mrd, mavail, exp_pops, exp_ur, base_pop, base_ur;
    int len, t0;
    bit rj, hold;
    logic [31:0] w;
    string tag;

    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b1; fsync = 1'b0;
    cfg_pcm = pcm; cfg_just = 2'(just); cfg_delay = 2'(dly);
    cfg_width_m1 = 5'(wm1); cfg_chans = 2'(ch);
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0 && fifo_pop == 1'b0 && underrun == 1'b0, "R1",
        "outputs in reset", int'({sdo, fifo_pop, underrun}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo == 1'b0 && underrun == 1'b0, "R1", "outputs after reset",
        int'({sdo, underrun}), 0);

    for (int i = 0; i < nwords; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      fmem[wr_ptr % 1024] = seed;
      wr_ptr++;
    end
    base_pop = pop_cnt; base_ur = ur_cnt;
    mrd = rd_ptr; mavail = wr_ptr - rd_ptr;
    exp_pops = 0; exp_ur = 0;

    n  = pcm ? 2 * (ch + 1) : ch + 1;
    d  = pcm ? dly : ((just == 1 || just == 2) ? 0 : 1);
    rj = !pcm && just == 2;
    if (pcm) tag = "R5";
    else if (just == 1) tag = "R3";
    else if (just == 2) tag = "R4";
    else tag = "R2";

    for (int i = 0; i < 4096; i++) exp_bits[i] = 1'b0;
    total = 0;
    for (int i = 0; i < 3; i++) lvl[total++] = 1'b0;
    for (int h = 0; h < (pcm ? frames : 2 * frames); h++) begin
      t0 = total;
      if (pcm) begin
        len = 32 * n + d + extra;
        lvl[total++] = 1'b1;
        for (int k = 1; k < len; k++) lvl[total++] = 1'b0;
      end else begin
        len = 32 * n + extra;
        for (int k = 0; k < len; k++) lvl[total++] = (h % 2 == 0);
      end
      for (int s = 0; s < n; s++) begin
        if (mavail > 0) begin
          w = fmem[mrd % 1024]; mrd++; mavail--; exp_pops++;
        end else begin
          w = '0; exp_ur++;
        end
        for (int b = 0; b < 32; b++)
          if (t0 + d + 32 * s + b < 4096)
            exp_bits[t0 + d + 32 * s + b] = bitf(w, wm1, b, rj);
      end
    end
    hold = lvl[total-1];
    for (int i = 0; i < 40; i++) lvl[total++] = hold;

    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      bclk = 1'b0; fsync = lvl[t];
      repeat (3) @(negedge clk);
      chk(sdo == exp_bits[t], (t < 3) ? "R11" : tag,
          $sformatf("R6 R7 bit %0d (w=%0d ch=%0d)", t, wm1 + 1, ch),
          int'(sdo), int'(exp_bits[t]));
      bclk = 1'b1;
      @(negedge clk);
      chk(sdo == exp_bits[t], "R10", $sformatf("held bit %0d", t),
          int'(sdo), int'(exp_bits[t]));
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(pop_cnt - base_pop == exp_pops, "R8", "words taken (R7 slot count)",
        pop_cnt - base_pop, exp_pops);
    chk(ur_cnt - base_ur == exp_ur, "R9", "underrun pulses",
        ur_cnt - base_ur, exp_ur);
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b1; fsync = 1'b0; cfg_pcm = 1'b0;
    cfg_just = 2'd0; cfg_delay = 2'd0; cfg_width_m1 = 5'd31; cfg_chans = 2'd0;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 3; j++)
      for (int wi = 0; wi < 4; wi++)
        for (int c = 0; c < 2; c++)
          run_case(1'b0, j, 0, 8 * wi + 7, c, 2, (wi == 3) ? 0 : 2,
                   2 * 2 * (c + 1));
    run_case(1'b0, 3, 0, 15, 0, 1, 2, 2);
    for (int dl = 0; dl < 4; dl++)
      for (int wi = 0; wi < 2; wi++)
        for (int c = 0; c < 2; c++)
          run_case(1'b1, 1, dl, wi ? 31 : 15, 3 * c, 2, 3, 2 * 2 * (3 * c + 1));
    run_case(1'b0, 0, 0, 15, 0, 2, 2, 3);
    run_case(1'b1, 0, 2, 31, 1, 1, 3, 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule